// File: doc/BRIEF.md
# Keyboard Scan Code Port Controller

This block sits between a serial keyboard receiver and the processor's data bus. Each scan code byte that the receiver delivers with a one-cycle valid strobe is stored in a small first-in first-out queue. The oldest stored byte is always visible on the read data output. A one-cycle read strobe from the processor takes that byte and removes it from the queue. A level interrupt request tells the processor that bytes are waiting.

A system control port writes a 2-bit mode word through a write strobe. The mode selects normal queuing, silent discarding of incoming codes, or a keyboard reset. A reset mode either drops the interrupt or leaves it as it was. A reset lasts a fixed number of clock cycles, set by a parameter. When it expires, the queue is emptied, the self-test pass code 0xAA is placed in it as the only entry, and the interrupt is raised, as if the keyboard had just reported a good power-on test.

Top module: `kbd_scan_port`

## Requirements
- R1: After the synchronous reset, `irq` is 0, `cpu_data` is 0x00, the queue is empty and the mode is normal (code 01).
- R2: In mode 01, a code presented with `code_valid` is stored in arrival order and `irq` is 1 from the next cycle on.
- R3: Writing mode 11 (`mode_we` with `mode_wd` = 11) makes `irq` 0 on the next cycle. While mode 11 is in effect, arriving codes are discarded and the queue is unchanged.
- R4: Writing mode 10 makes `irq` 0 on the next cycle and starts a keyboard reset.
- R5: Writing mode 00 starts a keyboard reset and leaves `irq` unchanged.
- R6: A reset completes on the clock edge `RESET_CYCLES` edges after the edge that sampled the mode write. At that edge, the queue is cleared and any code or read in the same cycle is dropped. If the mode in effect is not 11, 0xAA becomes the only entry and `irq` is 1. In mode 11, the queue is left empty and no interrupt is raised.
- R7: Writing mode 00 or 10 while a reset is counting restarts the count from `RESET_CYCLES`.
- R8: `cpu_data` shows the oldest queued byte in the same cycle, without delay. A `cpu_rd` strobe removes that byte. After the read, `irq` is 1 if at least one byte remains, and 0 otherwise.
- R9: Reading an empty queue shows 0x00, changes no queue state and leaves `irq` at 0.
- R10: The queue holds `FIFO_DEPTH` (default 16) bytes. A code that arrives while the queue is full is dropped.
- R11: When a mode write that drops the interrupt (mode 10 or 11) lands in the same cycle as an event that would raise it, `irq` is 0 on the next cycle. Any code accepted in that cycle is still stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_we | input | 1 | Mode write strobe from the control port |
| mode_wd | input | 2 | Mode value: 01 normal, 11 discard, 10 reset and drop interrupt, 00 reset |
| code_valid | input | 1 | Scan code strobe from the receiver |
| code_byte | input | 8 | Scan code value |
| cpu_rd | input | 1 | Processor read strobe; removes the byte shown on `cpu_data` |
| cpu_data | output | 8 | Oldest queued byte, or 0x00 when the queue is empty |
| irq | output | 1 | Level interrupt request |

## Verification
Every strobe, whether a code, a read or a mode write, is sampled on one rising edge. Its effect on `irq` and on `cpu_data` is visible right after that edge, and the one exception is reset completion. Completion appears exactly `RESET_CYCLES` edges after the mode write. The bench drives inputs on falling edges and compares both outputs on every falling edge against a behavioural queue model. Directed checks sample one cycle before and at the completion edge to pin the reset delay and its restart. The checks also cover combined cases where a mode write and a raising event land in the same cycle, where a code arrives in discard mode, and where the queue is full.

// File: rtl/kbd_pkg.sv
package kbd_pkg;

    typedef enum logic [1:0] {
        KM_RESET_HOLD  = 2'b00,
        KM_NORMAL      = 2'b01,
        KM_RESET_QUIET = 2'b10,
        KM_DISCARD     = 2'b11
    } kbd_mode_e;

    localparam logic [7:0] SELFTEST_PASS = 8'hAA;
    localparam logic [7:0] EMPTY_READ    = 8'h00;

    typedef struct packed {
        logic       valid;
        logic [7:0] data;
    } kbd_byte_t;

    function automatic logic mode_lowers_irq(kbd_mode_e m);
        return m[1];
    endfunction

    function automatic logic mode_starts_reset(kbd_mode_e m);
        return !m[0];
    endfunction

    function automatic logic mode_accepts(kbd_mode_e m);
        return m != KM_DISCARD;
    endfunction

endpackage

// File: rtl/kbd_code_fifo.sv
module kbd_code_fifo
    import kbd_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           flush,
    input  logic                           flush_load,
    input  logic [7:0]                     flush_byte,
    input  kbd_byte_t                      wr,
    input  logic                           rd_en,
    output logic [7:0]                     head,
    output logic [$clog2(DEPTH+1)-1:0]     count,
    output logic                           empty,
    output logic                           full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [7:0]    mem [DEPTH];
    logic [AW-1:0] rptr, wptr;

    function automatic logic [AW-1:0] step(logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            rptr  <= '0;
            wptr  <= '0;
            count <= '0;
        end else if (flush) begin
            rptr  <= '0;
            wptr  <= flush_load ? step('0) : '0;
            count <= flush_load ? CW'(1) : '0;
        end else begin
            if (wr.valid) wptr <= step(wptr);
            if (rd_en)    rptr <= step(rptr);
            count <= count + CW'(wr.valid) - CW'(rd_en);
        end
    end

    always_ff @(posedge clk) begin
        if (flush && flush_load)
            mem[0] <= flush_byte;
        else if (!flush && wr.valid)
            mem[wptr] <= wr.data;
    end

    assign head  = mem[rptr];
    assign empty = (count == '0);
    assign full  = (count == CW'(DEPTH));

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        count <= CW'(DEPTH)); // R10

endmodule

// File: rtl/kbd_reset_timer.sv
module kbd_reset_timer #(
    parameter int DELAY = 5
) (
    input  logic clk,
    input  logic rst,
    input  logic reload,
    output logic busy,
    output logic done
);
    localparam int CW = $clog2(DELAY + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (reload)
            cnt <= CW'(DELAY);
        else if (busy)
            cnt <= cnt - CW'(1);
    end

    assign busy = (cnt != '0);
    assign done = (cnt == CW'(1)) && !reload;

    AST_RELOAD_FULL: assert property (@(posedge clk) disable iff (rst)
        reload |=> cnt == CW'(DELAY)); // R7
    AST_COUNT_DOWN: assert property (@(posedge clk) disable iff (rst)
        (busy && !reload) |=> cnt == $past(cnt) - CW'(1)); // R6

endmodule

// File: rtl/kbd_irq_ctrl.sv
module kbd_irq_ctrl (
    input  logic clk,
    input  logic rst,
    input  logic force_low,
    input  logic raise,
    input  logic read_low,
    output logic irq
);
    always_ff @(posedge clk) begin
        if (rst)
            irq <= 1'b0;
        else if (force_low)
            irq <= 1'b0;
        else if (raise)
            irq <= 1'b1;
        else if (read_low)
            irq <= 1'b0;
    end
endmodule

// File: rtl/kbd_scan_port.sv
module kbd_scan_port
    import kbd_pkg::*;
#(
    parameter int FIFO_DEPTH   = 16,
    parameter int RESET_CYCLES = 5
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       mode_we,
    input  logic [1:0] mode_wd,
    input  logic       code_valid,
    input  logic [7:0] code_byte,
    input  logic       cpu_rd,
    output logic [7:0] cpu_data,
    output logic       irq
);
    localparam int CW = $clog2(FIFO_DEPTH + 1);

    kbd_mode_e     mode_q, mode_new;
    logic          reload, lower_mode, reset_done, reset_busy, inject;
    logic          push_ok, pop_ok, rd_raise, raise;
    logic          full, empty;
    logic [CW-1:0] count;
    logic [7:0]    head;
    kbd_byte_t     arrive;

    assign mode_new = kbd_mode_e'(mode_wd);

    always_ff @(posedge clk) begin
        if (rst)
            mode_q <= KM_NORMAL;
        else if (mode_we)
            mode_q <= mode_new;
    end

    assign reload     = mode_we && mode_starts_reset(mode_new);
    assign lower_mode = mode_we && mode_lowers_irq(mode_new);

    kbd_reset_timer #(.DELAY(RESET_CYCLES)) u_timer (
        .clk   (clk),
        .rst   (rst),
        .reload(reload),
        .busy  (reset_busy),
        .done  (reset_done)
    );

    assign inject  = reset_done && mode_accepts(mode_q);
    assign push_ok = code_valid && mode_accepts(mode_q) && !full && !reset_done;
    assign pop_ok  = cpu_rd && !empty && !reset_done;
    assign arrive  = '{valid: push_ok, data: code_byte};

    kbd_code_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
        .clk       (clk),
        .rst       (rst),
        .flush     (reset_done),
        .flush_load(inject),
        .flush_byte(SELFTEST_PASS),
        .wr        (arrive),
        .rd_en     (pop_ok),
        .head      (head),
        .count     (count),
        .empty     (empty),
        .full      (full)
    );

    assign rd_raise = pop_ok && (count > CW'(1));
    assign raise    = push_ok || inject || rd_raise;

    kbd_irq_ctrl u_irq (
        .clk      (clk),
        .rst      (rst),
        .force_low(lower_mode),
        .raise    (raise),
        .read_low (cpu_rd),
        .irq      (irq)
    );

    assign cpu_data = empty ? EMPTY_READ : head;

    AST_DISCARD_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (mode_q == KM_DISCARD && code_valid && !cpu_rd && !reset_done)
        |=> count == $past(count)); // R3
    AST_QUIET_RESET_LOWERS: assert property (@(posedge clk) disable iff (rst)
        (mode_we && mode_wd == 2'b10) |=> !irq); // R4
    AST_HOLD_KEEPS_IRQ: assert property (@(posedge clk) disable iff (rst)
        (mode_we && mode_wd == 2'b00 && !code_valid && !cpu_rd && !reset_done)
        |=> irq == $past(irq)); // R5
    AST_INJECT_SELFTEST: assert property (@(posedge clk) disable iff (rst)
        (reset_done && mode_q != KM_DISCARD && !lower_mode)
        |=> (count == CW'(1) && cpu_data == 8'hAA && irq)); // R6
    AST_EMPTY_READ_INERT: assert property (@(posedge clk) disable iff (rst)
        (cpu_rd && empty && !code_valid && !reset_done)
        |=> (count == '0 && cpu_data == 8'h00)); // R9
    AST_FULL_DROP: assert property (@(posedge clk) disable iff (rst)
        (full && code_valid && !cpu_rd && !reset_done) |=> full); // R10
    AST_LOWER_WINS: assert property (@(posedge clk) disable iff (rst)
        (lower_mode && raise) |=> !irq); // R11

endmodule

// File: tb/sim_kbd_scan_port.sv
module sim_kbd_scan_port;
    localparam int DEPTH = 16;
    localparam int DLY   = 5;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       mode_we = 1'b0;
    logic [1:0] mode_wd = 2'b01;
    logic       code_valid = 1'b0;
    logic [7:0] code_byte = 8'h00;
    logic       cpu_rd = 1'b0;
    logic [7:0] cpu_data;
    logic       irq;

    int    n_cmp = 0;
    int    n_bad = 0;
    int    cycles = 0;
    string cur_req = "R1";

    always #4 clk = ~clk;

    kbd_scan_port #(.FIFO_DEPTH(DEPTH), .RESET_CYCLES(DLY)) u0 (
        .clk(clk), .rst(rst), .mode_we(mode_we), .mode_wd(mode_wd),
        .code_valid(code_valid), .code_byte(code_byte), .cpu_rd(cpu_rd),
        .cpu_data(cpu_data), .irq(irq)
    );

    // behavioural reference
    int mq[$];
    int m_mode = 1;
    int m_cnt  = 0;
    bit m_irq  = 0;

    always @(posedge clk) begin
        if (rst) begin
            mq.delete();
            m_mode = 1; m_cnt = 0; m_irq = 0;
        end else begin
            bit reload, lower, done, push, pop, more, rais;
            reload = mode_we && (mode_wd == 2'b00 || mode_wd == 2'b10);
            lower  = mode_we && mode_wd[1];
            done   = (m_cnt == 1) && !reload;
            push   = !done && code_valid && m_mode != 3 && mq.size() < DEPTH;
            pop    = !done && cpu_rd && mq.size() > 0;
            more   = mq.size() > 1;
            rais   = push || (done && m_mode != 3) || (pop && more);
            if (done) begin
                mq.delete();
                if (m_mode != 3) mq.push_back(8'hAA);
            end else begin
                if (pop)  void'(mq.pop_front());
                if (push) mq.push_back(int'(code_byte));
            end
            if (lower)       m_irq = 0;
            else if (rais)   m_irq = 1;
            else if (cpu_rd) m_irq = 0;
            if (reload)         m_cnt = DLY;
            else if (m_cnt > 0) m_cnt = m_cnt - 1;
            if (mode_we) m_mode = int'(mode_wd);
        end
    end

    always @(negedge clk) begin
        cycles++;
        if (!rst) begin
            int exp_d;
            exp_d = (mq.size() > 0) ? mq[0] : 0;
            n_cmp += 2;
            if (irq !== m_irq) begin
                n_bad++;
                $display("FAIL %s model irq: got %0b expected %0b", cur_req, irq, m_irq);
            end
            if (cpu_data !== 8'(exp_d)) begin
                n_bad++;
                $display("FAIL %s model data: got %02h expected %02h", cur_req, cpu_data, exp_d);
            end
        end
        if (cycles > 100000) begin
            n_bad++;
            $display("FAIL watchdog expired: got %0d cycles expected under 100000", cycles);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    task automatic chk(string req, logic [7:0] got, logic [7:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %02h expected %02h", req, got, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
        mode_we = 0; code_valid = 0; cpu_rd = 0;
    endtask

    task automatic push(logic [7:0] b);
        code_valid = 1; code_byte = b; tick();
    endtask

    task automatic rd();
        cpu_rd = 1; tick();
    endtask

    task automatic setmode(logic [1:0] m);
        mode_we = 1; mode_wd = m; tick();
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    initial begin
        idle(3);
        rst = 0;
        tick();
        cur_req = "R1";
        chk("R1 irq", 8'(irq), 8'h00);
        chk("R1 data", cpu_data, 8'h00);

        cur_req = "R2";
        push(8'h1C); chk("R2 irq", 8'(irq), 8'h01); chk("R2 head", cpu_data, 8'h1C);
        push(8'h32); push(8'h45);
        chk("R2 order", cpu_data, 8'h1C);

        cur_req = "R8";
        rd(); chk("R8 next", cpu_data, 8'h32); chk("R8 irq kept", 8'(irq), 8'h01);
        rd(); chk("R8 last", cpu_data, 8'h45);
        rd(); chk("R8 irq low", 8'(irq), 8'h00);

        cur_req = "R9";
        rd(); chk("R9 data", cpu_data, 8'h00); chk("R9 irq", 8'(irq), 8'h00);

        cur_req = "R3";
        push(8'h21);
        setmode(2'b11); chk("R3 irq low", 8'(irq), 8'h00); chk("R3 kept", cpu_data, 8'h21);
        push(8'h77); push(8'h78);
        rd(); chk("R3 discarded", cpu_data, 8'h00);
        setmode(2'b01);

        cur_req = "R4";
        push(8'h11);
        setmode(2'b10); chk("R4 irq low", 8'(irq), 8'h00);
        cur_req = "R6";
        idle(DLY - 1); chk("R6 before", cpu_data, 8'h11);
        idle(1); chk("R6 code", cpu_data, 8'hAA); chk("R6 irq", 8'(irq), 8'h01);
        rd(); chk("R6 single", cpu_data, 8'h00);
        setmode(2'b01);

        cur_req = "R5";
        push(8'h05);
        setmode(2'b00); chk("R5 irq kept", 8'(irq), 8'h01);
        idle(DLY - 1); chk("R5 irq still", 8'(irq), 8'h01);
        idle(1); chk("R5 done", cpu_data, 8'hAA);
        rd();

        cur_req = "R7";
        setmode(2'b01);
        push(8'h66);
        setmode(2'b00);
        idle(2);
        setmode(2'b00);
        idle(DLY - 1); chk("R7 restarted", cpu_data, 8'h66);
        idle(1); chk("R7 done", cpu_data, 8'hAA);
        rd();

        cur_req = "R6";
        setmode(2'b01);
        push(8'h40);
        setmode(2'b10);
        idle(1);
        setmode(2'b11);
        idle(DLY - 2);
        chk("R6 discard done data", cpu_data, 8'h00);
        chk("R6 discard done irq", 8'(irq), 8'h00);
        setmode(2'b01);

        cur_req = "R10";
        for (int i = 0; i < DEPTH + 1; i++) push(8'(8'h80 + i));
        for (int i = 0; i < DEPTH; i++) begin
            chk("R10 entry", cpu_data, 8'(8'h80 + i));
            rd();
        end
        chk("R10 dropped", cpu_data, 8'h00);

        cur_req = "R11";
        code_valid = 1; code_byte = 8'h3A; mode_we = 1; mode_wd = 2'b10; tick();
        chk("R11 irq", 8'(irq), 8'h00); chk("R11 stored", cpu_data, 8'h3A);
        idle(DLY + 2);
        rd(); setmode(2'b01);
        idle(2);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule